// File: doc/BRIEF.md
# Parallel Xorshift Bitstream Generator

This block produces a wide word of pseudo-random bits on every enabled clock cycle. It does this by running several Xorshift shift registers side by side. Each register advances once per enabled cycle with three shift-and-XOR steps. The registers are laid next to one another, lowest lane in the lowest bits, and the joined vector is cut down to the requested output width.

A single packed seed parameter holds one slice per register. The block loads the seeds whenever the synchronous reset is high. A registered valid flag tells the next stage in a processing chain which cycles carry a fresh word. Because each register advances at most once per clock, the whole word costs one cycle of latency from the enable.

Top module: `xs_bitgen`

## Requirements
- R1: When enabled, each register of width REG_W moves from x to x3 in one clock, where x1 = x ^ (x << SH_A), x2 = x1 ^ (x1 >> SH_B) and x3 = x2 ^ (x2 << SH_C). All shifts are logical and truncated to REG_W bits.
- R2: The block instantiates ceil(OUT_BITS/REG_W) registers. Register k occupies bits [k*REG_W +: REG_W] of the joined vector.
- R3: `bits_out` is the low OUT_BITS bits of the joined vector. Whatever register bits lie above OUT_BITS are not driven out.
- R4: A clock edge with `rst` high loads register k with SEED[k*REG_W +: REG_W] and clears `valid_out`. The registered seed words are visible on `bits_out` in the following cycle.
- R5: After an edge with `rst` low and `en` high, `valid_out` is 1 and `bits_out` shows the next word. The first valid word after reset is therefore one step past the seed.
- R6: After an edge with `rst` low and `en` low, `valid_out` is 0 and `bits_out` keeps its previous value.
- R7: A reset asserted mid-run restarts every register from its seed slice. The sequence after the reset repeats the one seen after the first reset.
- R8: A register whose seed slice is nonzero never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; reloads seeds |
| en | input | 1 | Advance all registers on this edge |
| bits_out | output | OUT_BITS | Current pseudo-random word |
| valid_out | output | 1 | High when `bits_out` holds a word produced by an enabled step |

## Verification
The bench builds two instances side by side. The first has 64-bit registers and a 100-bit output: two lanes, with the second lane cut to 36 bits. The second has 32-bit registers, a different shift triple and a 70-bit output, giving three lanes with the top lane cut to 6 bits. Together they cover an uneven lane count, truncation inside a lane, and a second set of shift amounts. A reference step model per lane then predicts every word through enabled, stalled, alternating and mid-run reset stretches.

// File: rtl/xs_pkg.sv
package xs_pkg;

    // Number of registers needed to cover a word of the given width.
    function automatic int lanes_for(input int out_bits, input int reg_w);
        return (out_bits + reg_w - 1) / reg_w;
    endfunction

endpackage

// File: rtl/xs_lane.sv
module xs_lane #(
    parameter int W = 64,
    parameter int A = 13,
    parameter int B = 7,
    parameter int C = 17,
    parameter logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state
);

    typedef struct packed {
        logic [W-1:0] st;
    } lane_t;

    lane_t s_d, s_q;

    // Three shift-and-XOR stages in one cycle: left A, right B, left C.
    function automatic logic [W-1:0] step(input logic [W-1:0] x);
        logic [W-1:0] y;
        y = x ^ (x << A);
        y = y ^ (y >> B);
        y = y ^ (y << C);
        return y;
    endfunction

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.st = SEED;
        end else if (adv) begin
            s_d.st = step(s_q.st);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign state = s_q.st;

    // R4: a reset edge leaves the seed slice in the register.
    p_seed_load_r4: assert property (@(posedge clk)
        rst |=> state == SEED);

    // R6: no advance means the register holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

    // R1: a nonzero state is never a fixed point of the step.
    generate
        if (SEED != '0) begin : g_moves
            p_moves_r1: assert property (@(posedge clk) disable iff (rst)
                adv |=> state != $past(state));
        end
    endgenerate

endmodule

// File: rtl/xs_valid.sv
module xs_valid (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic valid
);

    typedef struct packed {
        logic vld;
    } vseq_t;

    vseq_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (rst) begin
            v_d.vld = 1'b0;
        end else begin
            v_d.vld = en;
        end
    end

    always_ff @(posedge clk) begin
        v_q <= v_d;
    end

    assign valid = v_q.vld;

    // R4: valid is low in the cycle after any reset edge.
    p_clear_on_reset_r4: assert property (@(posedge clk)
        rst |=> !valid);

endmodule

// File: rtl/xs_bitgen.sv
module xs_bitgen import xs_pkg::*; #(
    parameter int OUT_BITS = 100,
    parameter int REG_W    = 64,
    parameter int SH_A     = 13,
    parameter int SH_B     = 7,
    parameter int SH_C     = 17,
    parameter logic [REG_W*((OUT_BITS+REG_W-1)/REG_W)-1:0] SEED =
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [OUT_BITS-1:0] bits_out,
    output logic                valid_out
);

    localparam int NLANES  = lanes_for(OUT_BITS, REG_W);
    localparam int TOTAL_W = NLANES * REG_W;

    logic [TOTAL_W-1:0] lane_bus;

    generate
        for (genvar k = 0; k < NLANES; k++) begin : g_lane
            xs_lane #(
                .W    (REG_W),
                .A    (SH_A),
                .B    (SH_B),
                .C    (SH_C),
                .SEED (SEED[k*REG_W +: REG_W])
            ) u_lane (
                .clk   (clk),
                .rst   (rst),
                .adv   (en),
                .state (lane_bus[k*REG_W +: REG_W])
            );

            // R8: a lane started from a nonzero seed never collapses to zero.
            if (SEED[k*REG_W +: REG_W] != '0) begin : g_nz
                p_lane_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
                    lane_bus[k*REG_W +: REG_W] != '0);
            end
        end
    endgenerate

    xs_valid u_valid (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .valid (valid_out)
    );

    assign bits_out = lane_bus[OUT_BITS-1:0];

    // R5: every valid cycle carries a freshly stepped lane 0.
    generate
        if (SEED[REG_W-1:0] != '0) begin : g_fresh
            p_valid_fresh_r5: assert property (@(posedge clk) disable iff (rst)
                valid_out |-> lane_bus[REG_W-1:0] != $past(lane_bus[REG_W-1:0]));
        end
    endgenerate

endmodule

// File: tb/tb_xs_bitgen.sv
`timescale 1ns/1ps
module tb_xs_bitgen;

    localparam logic [127:0] SEED_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [95:0]  SEED_B = 96'h89AB_CDEF_1357_9BDF_2468_ACE0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [99:0] out_a;
    logic [69:0] out_b;
    logic        vld_a, vld_b;

    always #2 clk = ~clk;

    xs_bitgen #(.OUT_BITS(100), .REG_W(64), .SH_A(13), .SH_B(7), .SH_C(17),
                .SEED(SEED_A)) dut (
        .clk(clk), .rst(rst), .en(en), .bits_out(out_a), .valid_out(vld_a));

    xs_bitgen #(.OUT_BITS(70), .REG_W(32), .SH_A(13), .SH_B(17), .SH_C(5),
                .SEED(SEED_B)) dut_b (
        .clk(clk), .rst(rst), .en(en), .bits_out(out_b), .valid_out(vld_b));

    typedef struct {
        logic        v;
        logic [99:0] wa;
        logic [69:0] wb;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] ma [2];
    logic [31:0] mb [3];

    function automatic logic [63:0] ref64(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    function automatic logic [31:0] ref32(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply inputs, predict the post-edge outputs, push them.
    task automatic step(input logic r, input logic e, input string tag);
        exp_t it;
        if (r) begin
            for (int k = 0; k < 2; k++) ma[k] = SEED_A[k*64 +: 64];
            for (int k = 0; k < 3; k++) mb[k] = SEED_B[k*32 +: 32];
            it.v = 1'b0;
        end else if (e) begin
            for (int k = 0; k < 2; k++) ma[k] = ref64(ma[k]);
            for (int k = 0; k < 3; k++) mb[k] = ref32(mb[k]);
            it.v = 1'b1;
        end else begin
            it.v = 1'b0;
        end
        it.wa  = {ma[1][35:0], ma[0]};
        it.wb  = {mb[2][5:0], mb[1], mb[0]};
        it.tag = tag;
        q.push_back(it);
        rst = r;
        en  = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare one expected item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                chk(vld_a === it.v, {it.tag, " valid_a"}, 128'(vld_a), 128'(it.v));
                chk(vld_b === it.v, {it.tag, " valid_b"}, 128'(vld_b), 128'(it.v));
                chk(out_a[63:0] === it.wa[63:0], {it.tag, " R1 lane0 step"},
                    128'(out_a[63:0]), 128'(it.wa[63:0]));
                chk(out_a[99:64] === it.wa[99:64], {it.tag, " R3 truncated lane1"},
                    128'(out_a[99:64]), 128'(it.wa[99:64]));
                chk(out_b === it.wb, {it.tag, " R2 three lanes"},
                    128'(out_b), 128'(it.wb));
                if (it.v) begin
                    chk(out_a[63:0] != '0, {it.tag, " R8 nonzero"},
                        128'(out_a[63:0]), 128'h1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R4: reset loads seeds, valid low
        repeat (3) step(1'b1, 1'b0, "R4");
        // R5: continuous run from the seed
        repeat (40) step(1'b0, 1'b1, "R5");
        // R6: stall, words must hold
        repeat (5) step(1'b0, 1'b0, "R6");
        // R5/R6: mixed enable pattern
        for (int i = 0; i < 30; i++) step(1'b0, (i % 3) != 0, "R5R6");
        // R7: reset in the middle of a run, then the same sequence again
        step(1'b1, 1'b1, "R7");
        repeat (40) step(1'b0, 1'b1, "R7");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule